// File: doc/BRIEF.md
# I2C incomplete-write fault injector

This block is an I2C bus master whose only job is to leave the bus stuck on purpose, so that the bus-recovery logic of another master can be tried against a realistic hang. A one-cycle trigger starts a run for a 7-bit target address. The block issues a START and sends the address with the write direction bit. It then samples the acknowledge. If the target acknowledges, the block sends one data byte of value zero and then stops inside the acknowledge slot of that byte. At that point SCL is held low, SDA is released, and no STOP is ever sent. The addressed target keeps pulling SDA low because it is still acknowledging, and only a correct recovery sequence frees the bus.

If the address is not acknowledged, the block ends the transfer cleanly with a STOP and raises a not-acknowledged flag. Both lines use an open-drain model. A `*_oe_o` output high means "pull the line low", and the real line level comes back on `scl_i` and `sda_i`. Bus timing comes from a programmable divider: one quarter of a bit period lasts `div_i + 1` clock cycles. While the block has released SCL, it waits as long as the line is still held low by another device.

States: `ST_IDLE`, `ST_START`, `ST_LOW_A`, `ST_LOW_B`, `ST_HIGH`, `ST_STOP_LOW_A`, `ST_STOP_LOW_B`, `ST_STOP_HIGH`, `ST_HALT`. Transitions:
- trigger: `ST_IDLE` to `ST_START`.
- quarter timer ends:
  - `ST_START` to `ST_LOW_A`.
  - `ST_LOW_A` to `ST_LOW_B`.
  - `ST_LOW_B` to `ST_HIGH`, or to `ST_HALT` in the data acknowledge slot.
  - `ST_HIGH` to `ST_LOW_A`, or to `ST_STOP_LOW_A` on an address NACK.
  - `ST_STOP_LOW_A` to `ST_STOP_LOW_B` to `ST_STOP_HIGH` to `ST_IDLE`.
- `ST_HALT` is left only by reset.

Top module: `i2c_fault_injector`

## Requirements
- R1: After reset, both `scl_oe_o` and `sda_oe_o` are 0 (lines released). `busy_o`, `done_o`, `addr_ack_o` and `addr_nack_o` are all 0.
- R2: Every quarter lasts `div_i + 1` cycles. A bit slot is two quarters with SCL driven low (`scl_oe_o`=1), then two quarters with SCL released. START lasts two quarters.
- R3: A START is `sda_oe_o` going to 1 while SCL is released, taken from the idle state. Within a bit slot, `sda_oe_o` changes only at the start of the second low quarter.
- R4: The first frame carries the 7 address bits MSB first and then a direction bit of 0. A 0 bit is sent as `sda_oe_o`=1 and a 1 bit as `sda_oe_o`=0. In the ninth slot SDA is released, and `sda_i` is sampled on the last cycle of that slot's high phase: 0 means ACK.
- R5: After an address ACK, eight slots with `sda_oe_o`=1 (value 0x00) follow. In the ninth slot SDA is released in the second low quarter, and the block then holds SCL low (`scl_oe_o`=1, `sda_oe_o`=0) until reset. No STOP is issued.
- R6: `addr_ack_o` rises the cycle after an ACK is sampled. On a NACK, `addr_nack_o` rises and a STOP follows: SCL low for one quarter, SDA driven for one quarter, SCL released for two quarters, then SDA released with SCL high. The two flags are never both 1, and both clear when a new run starts.
- R7: `busy_o` is 1 from the cycle after the trigger is taken until `ST_HALT` or `ST_IDLE` is reached.
- R8: `done_o` is a single-cycle pulse on the first cycle of `ST_HALT`, once per run.
- R9: A trigger while busy or halted is ignored and leaves the outputs unchanged.
- R10: While SCL is released but `scl_i` reads low, the quarter timer does not advance, so the phase is stretched by exactly the held cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Trigger, taken only in `ST_IDLE` |
| addr_i | input | 7 | Target address, captured with the trigger |
| div_i | input | DIV_W | Quarter length minus one, held stable during a run |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Pulse on entry to the halted state |
| addr_ack_o | output | 1 | Address acknowledged in this run |
| addr_nack_o | output | 1 | Address not acknowledged in this run |

## Verification
The hardest situation to reach is the halted state. It needs an acknowledged address and a full zero byte, and only then an open acknowledge slot with the target still holding SDA. The bench gets there with a behavioural target that pulls SDA in the acknowledge slots only for its own address. It then keeps triggering while the block is halted, to show that the stuck condition stays put. Clock stretching is reached by a bench signal that holds the SCL line low in a repeating pattern across a whole run. The reference model pauses its own timeline on the same cycles.

// File: rtl/i2c_fi_pkg.sv
package i2c_fi_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_LOW_A,
        ST_LOW_B,
        ST_HIGH,
        ST_STOP_LOW_A,
        ST_STOP_LOW_B,
        ST_STOP_HIGH,
        ST_HALT
    } fi_state_e;

endpackage

// File: rtl/i2c_fi_qtimer.sv
module i2c_fi_qtimer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W:0]   limit,
    output logic             qend
);

    logic [DIV_W:0] cnt_q;

    assign qend = run && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (qend) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: the counter never runs past the current phase length
    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= limit));

endmodule

// File: rtl/i2c_fi_shreg.sv
module i2c_fi_shreg #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] load_val,
    output logic         msb
);

    logic [W-1:0] sr_q;

    assign msb = sr_q[W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '1;
        end else if (load) begin
            sr_q <= load_val;
        end else if (shift) begin
            sr_q <= {sr_q[W-2:0], 1'b1};
        end
    end

    // R4: a frame is never loaded and shifted in the same cycle
    assert_single_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));

endmodule

// File: rtl/i2c_fault_injector.sv
module i2c_fault_injector
    import i2c_fi_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe_o,
    output logic              sda_oe_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              addr_ack_o,
    output logic              addr_nack_o
);

    localparam int DATA_W  = ADDR_W + 1;
    localparam int FRAME_W = DATA_W + 1;
    localparam int CNT_W   = $clog2(FRAME_W);

    fi_state_e          state, state_d;
    logic [CNT_W-1:0]   bit_cnt;
    logic               data_phase;
    logic               ack_q, nack_q;
    logic               scl_oe_q, sda_oe_q, done_q;
    logic               qend, run, two_q, last_slot;
    logic [DIV_W:0]     limit;
    logic               ld, sh, frame_msb;
    logic [FRAME_W-1:0] ld_val;

    assign last_slot = (bit_cnt == CNT_W'(FRAME_W - 1));
    assign two_q     = (state == ST_START) || (state == ST_HIGH) || (state == ST_STOP_HIGH);
    assign limit     = two_q ? {div_i, 1'b1} : {1'b0, div_i};

    always_comb begin
        unique case (state)
            ST_START, ST_HIGH, ST_STOP_HIGH:                   run = scl_i;
            ST_LOW_A, ST_LOW_B, ST_STOP_LOW_A, ST_STOP_LOW_B: run = 1'b1;
            default:                                           run = 1'b0;
        endcase
    end

    i2c_fi_qtimer #(.DIV_W(DIV_W)) u_qtimer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .limit (limit),
        .qend  (qend)
    );

    assign ld     = ((state == ST_IDLE) && start_i) ||
                    ((state == ST_HIGH) && qend && last_slot && !data_phase && !sda_i);
    assign sh     = (state == ST_HIGH) && qend && !last_slot;
    assign ld_val = (state == ST_IDLE) ? {addr_i, 1'b0, 1'b1} : {{DATA_W{1'b0}}, 1'b1};

    i2c_fi_shreg #(.W(FRAME_W)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .shift    (sh),
        .load_val (ld_val),
        .msb      (frame_msb)
    );

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:       if (start_i) state_d = ST_START;
            ST_START:      if (qend) state_d = ST_LOW_A;
            ST_LOW_A:      if (qend) state_d = ST_LOW_B;
            ST_LOW_B:      if (qend) state_d = (data_phase && last_slot) ? ST_HALT : ST_HIGH;
            ST_HIGH:       if (qend) state_d = (!data_phase && last_slot && sda_i) ? ST_STOP_LOW_A
                                                                                  : ST_LOW_A;
            ST_STOP_LOW_A: if (qend) state_d = ST_STOP_LOW_B;
            ST_STOP_LOW_B: if (qend) state_d = ST_STOP_HIGH;
            ST_STOP_HIGH:  if (qend) state_d = ST_IDLE;
            ST_HALT:       state_d = ST_HALT;
            default:       state_d = ST_IDLE;
        endcase
    end

    // State register and run bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            data_phase <= 1'b0;
            ack_q      <= 1'b0;
            nack_q     <= 1'b0;
        end else begin
            state <= state_d;
            if ((state == ST_IDLE) && start_i) begin
                bit_cnt    <= '0;
                data_phase <= 1'b0;
                ack_q      <= 1'b0;
                nack_q     <= 1'b0;
            end else if ((state == ST_HIGH) && qend) begin
                if (last_slot) begin
                    bit_cnt    <= '0;
                    data_phase <= 1'b1;
                    ack_q      <= !sda_i;
                    nack_q     <= sda_i;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // Output register, computed from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_oe_q <= 1'b0;
            sda_oe_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            scl_oe_q <= (state_d == ST_LOW_A) || (state_d == ST_LOW_B) ||
                        (state_d == ST_STOP_LOW_A) || (state_d == ST_STOP_LOW_B) ||
                        (state_d == ST_HALT);
            done_q   <= (state_d == ST_HALT) && (state != ST_HALT);
            unique case (state_d)
                ST_START, ST_STOP_LOW_B, ST_STOP_HIGH: sda_oe_q <= 1'b1;
                ST_LOW_B:                              sda_oe_q <= !frame_msb;
                ST_IDLE:                               sda_oe_q <= 1'b0;
                default:                               sda_oe_q <= sda_oe_q;
            endcase
        end
    end

    assign scl_oe_o    = scl_oe_q;
    assign sda_oe_o    = sda_oe_q;
    assign done_o      = done_q;
    assign busy_o      = (state != ST_IDLE) && (state != ST_HALT);
    assign addr_ack_o  = ack_q;
    assign addr_nack_o = nack_q;

    // R3: SDA is steady through a data high phase
    assert_sda_steady_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HIGH) && ($past(state) == ST_HIGH)) |-> $stable(sda_oe_o));
    // R5: the halted state holds SCL low with SDA released
    assert_halt_lines_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (scl_oe_o && !sda_oe_o && !done_o));
    // R6: the two acknowledge flags exclude each other
    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_ack_o && addr_nack_o));
    // R7: done never coincides with busy
    assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    // R8: done is a single-cycle pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R10: a held-low SCL freezes the high phase
    assert_stretch_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HIGH) && !scl_i) |=> (state == ST_HIGH));

endmodule

// File: tb/i2c_fault_injector_tb.sv
module i2c_fault_injector_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 16;
    localparam logic [6:0] TGT_ADDR = 7'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [6:0] addr = '0;
    logic [DIV_W-1:0] div = 16'd3;
    logic stretch = 1'b0;
    logic tgt_pull = 1'b0;
    logic scl_line, sda_line;
    logic scl_oe, sda_oe, busy, done, ack, nack;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // model state: {pull, scl_oe, sda_oe, busy, done, ack, nack}
    logic [6:0] exp_q[$];
    logic [6:0] steady = '0;
    bit m_ready = 1'b0;

    // monitor counters
    bit clr_mon = 1'b0;
    int start_cnt, stop_cnt, rise_cnt, done_cnt;
    logic p_scl = 1'b1, p_sda = 1'b1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign scl_line = ~scl_oe & ~stretch;
    assign sda_line = ~(sda_oe | tgt_pull);

    i2c_fault_injector #(.DIV_W(DIV_W), .ADDR_W(7)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .addr_i      (addr),
        .div_i       (div),
        .scl_i       (scl_line),
        .sda_i       (sda_line),
        .scl_oe_o    (scl_oe),
        .sda_oe_o    (sda_oe),
        .busy_o      (busy),
        .done_o      (done),
        .addr_ack_o  (ack),
        .addr_nack_o (nack)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [6:0] v, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(v);
    endtask

    // Behavioural timeline of one run
    task automatic build(input logic [6:0] a, input int d);
        int q;
        bit acked;
        logic prev, dr, p, bv;
        q = d + 1;
        acked = (a == TGT_ADDR);
        push(7'b0011000, 2 * q);
        prev = 1'b1;
        for (int i = 0; i < 9; i++) begin
            bv = (i < 7) ? a[6 - i] : (i == 7) ? 1'b0 : 1'b1;
            dr = ~bv;
            p  = (i == 8) && acked;
            push({p, 1'b1, prev, 4'b1000}, q);
            push({p, 1'b1, dr, 4'b1000}, q);
            push({p, 1'b0, dr, 4'b1000}, 2 * q);
            prev = dr;
        end
        if (acked) begin
            for (int i = 0; i < 8; i++) begin
                push({1'b0, 1'b1, prev, 4'b1010}, q);
                push({1'b0, 1'b1, 1'b1, 4'b1010}, q);
                push({1'b0, 1'b0, 1'b1, 4'b1010}, 2 * q);
                prev = 1'b1;
            end
            push({1'b1, 1'b1, prev, 4'b1010}, q);
            push({1'b1, 1'b1, 1'b0, 4'b1010}, q);
            push(7'b1100110, 1);
            steady = 7'b1100010;
        end else begin
            push(7'b0101001, q);
            push(7'b0111001, q);
            push(7'b0011001, 2 * q);
            steady = 7'b0000001;
        end
    endtask

    task automatic cmp(input logic [6:0] e);
        logic [5:0] act;
        string lbl;
        act = {scl_oe, sda_oe, busy, done, ack, nack};
        n_checks++;
        if (act !== e[5:0]) begin
            n_fail++;
            if (stretch)                 lbl = "R10";
            else if (act[5] !== e[5])    lbl = "R2";
            else if (act[4] !== e[4])    lbl = "R4";
            else if (act[3] !== e[3])    lbl = "R7";
            else if (act[2] !== e[2])    lbl = "R8";
            else                         lbl = "R6";
            $display("FAIL %s cycle %0d: {scl,sda,busy,done,ack,nack} actual %b expected %b",
                     lbl, cyc, act, e[5:0]);
        end
    endtask

    always @(posedge clk) begin
        if (rst_n && m_ready && start) begin
            build(addr, int'(div));
            m_ready = 1'b0;
        end
    end

    always @(negedge clk) begin
        logic [6:0] e;
        if (!rst_n) begin
            exp_q.delete();
            steady   = '0;
            m_ready  = 1'b0;
            tgt_pull = 1'b0;
        end else begin
            if (exp_q.size() > 0) begin
                e = exp_q[0];
                cmp(e);
                if (!(stretch && (e[5] == 1'b0))) void'(exp_q.pop_front());
            end else begin
                e = steady;
                cmp(e);
                m_ready = (steady[5] == 1'b0);
            end
            tgt_pull = e[6];
        end
    end

    // Bus event monitor
    always @(negedge clk) begin
        if (clr_mon) begin
            start_cnt = 0; stop_cnt = 0; rise_cnt = 0; done_cnt = 0;
        end else begin
            if (p_scl && scl_line && p_sda && !sda_line) start_cnt++;
            if (p_scl && scl_line && !p_sda && sda_line) stop_cnt++;
            if (!p_scl && scl_line) rise_cnt++;
            if (done) done_cnt++;
        end
        p_scl = scl_line;
        p_sda = sda_line;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic trigger(input logic [6:0] a, input logic [DIV_W-1:0] d);
        @(posedge clk); #1;
        addr = a; div = d; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic clear_mon();
        @(posedge clk); #1; clr_mon = 1'b1;
        @(posedge clk); #1; clr_mon = 1'b0;
    endtask

    task automatic do_reset();
        @(posedge clk); #1; rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1;
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check({scl_oe, sda_oe, busy, done, ack, nack} == 6'b0, "R1", "outputs in reset",
              int'({scl_oe, sda_oe, busy, done, ack, nack}), 0);
        #1; rst_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({scl_oe, sda_oe, busy} == 3'b0, "R1", "idle outputs after reset",
              int'({scl_oe, sda_oe, busy}), 0);

        // Run A: acknowledged address, ends halted
        clear_mon();
        trigger(TGT_ADDR, 16'd3);
        @(negedge clk);
        check(busy == 1'b1, "R7", "busy after trigger", int'(busy), 1);
        trigger(7'h11, 16'd3);     // ignored while busy
        repeat (600) @(posedge clk);
        @(negedge clk);
        check(done_cnt == 1, "R8", "done pulses", done_cnt, 1);
        check(start_cnt == 1, "R3", "START count", start_cnt, 1);
        check(rise_cnt == 17, "R4", "SCL high phases", rise_cnt, 17);
        check(stop_cnt == 0, "R5", "STOP count in halt run", stop_cnt, 0);
        check(ack == 1'b1 && nack == 1'b0, "R6", "ack flag", int'({ack, nack}), 2);
        trigger(TGT_ADDR, 16'd3);  // ignored while halted
        repeat (200) @(posedge clk);
        @(negedge clk);
        check(done_cnt == 1, "R9", "done pulses after halted trigger", done_cnt, 1);
        check(scl_oe == 1'b1 && sda_oe == 1'b0, "R5", "halt lines",
              int'({scl_oe, sda_oe}), 2);
        check(busy == 1'b0, "R9", "busy in halt", int'(busy), 0);

        // Run B: not acknowledged, shortest quarter, all-ones address
        do_reset();
        clear_mon();
        trigger(7'h7F, 16'd0);
        repeat (200) @(posedge clk);
        @(negedge clk);
        check(nack == 1'b1 && ack == 1'b0, "R6", "nack flag", int'({ack, nack}), 1);
        check(stop_cnt == 1, "R6", "STOP count", stop_cnt, 1);
        check(rise_cnt == 10, "R6", "SCL high phases with STOP", rise_cnt, 10);
        check(done_cnt == 0, "R8", "no done on nack", done_cnt, 0);
        check({scl_oe, sda_oe, busy} == 3'b0, "R6", "idle after STOP",
              int'({scl_oe, sda_oe, busy}), 0);

        // Run C: from idle, acknowledged, with SCL stretching
        clear_mon();
        trigger(TGT_ADDR, 16'd1);
        @(negedge clk);
        check(nack == 1'b0, "R6", "nack cleared by new run", int'(nack), 0);
        for (int k = 0; k < 600; k++) begin
            @(posedge clk); #1;
            stretch = ((k % 9) < 4);
        end
        @(posedge clk); #1; stretch = 1'b0;
        repeat (300) @(posedge clk);
        @(negedge clk);
        check(done_cnt == 1, "R10", "done after stretched run", done_cnt, 1);
        check(ack == 1'b1, "R10", "ack after stretched run", int'(ack), 1);

        // Run D: another quarter length
        do_reset();
        clear_mon();
        trigger(TGT_ADDR, 16'd2);
        repeat (500) @(posedge clk);
        @(negedge clk);
        check(done_cnt == 1, "R2", "done with quarter of 3", done_cnt, 1);
        check(stop_cnt == 0, "R5", "no STOP", stop_cnt, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule